// File: doc/BRIEF.md
# Out-of-Order Dispatch Scheduler with Early Tag Wakeup

This block holds decoded operations in a small pool of waiting slots. Operations arrive in program order. Each one names the execution unit it needs (adder, multiplier or divider), the tag it will produce, and two source tags, each with a flag that says whether the value is already available. A slot keeps watching the shared result-tag bus. Once both operands are available, the slot is handed to its execution unit. Each unit is a fully pipelined delay line with a fixed depth.

Each unit announces the destination tag of an operation on the shared bus one cycle before the operation leaves the unit. A consumer that wakes on that announcement can therefore be issued in the same cycle, so dependent operations run back to back. There is only one bus. Before an operation is issued, the scheduler checks that its future announcement cycle is still free. If that cycle is already reserved, the operation stays in its slot and tries again next cycle. Because every announcement has its own cycle, every completion has its own cycle as well, and results reach the reorder buffer one at a time.

A mode input limits issue to the single oldest waiting operation. This gives an in-order baseline that can be compared with the out-of-order mode.

Top module: `rs_scheduler`

## Requirements
- R1: While `rst_n` is low, `iss_valid`, `bc_valid` and `cmp_valid` are 0 and `ins_ready` is 1. All slots are empty after reset.
- R2: An operation accepted in cycle t (`ins_valid` and `ins_ready` high at the edge that ends cycle t) can be issued no earlier than cycle t+1.
- R3: `ins_op` encoding: 0 = add, 1 = multiply, 2 = divide, 3 = add. Issue is shown on `iss_valid` bit 0 (add), bit 1 (multiply) or bit 2 (divide). An operation issued in cycle t reports its destination tag on `cmp_tag`, with `cmp_valid` high, in cycle t+L. L is 3 for add, 5 for multiply and 7 for divide by default.
- R4: The destination tag of that operation is driven on `bc_tag`, with `bc_valid` high, in cycle t+L-1, exactly one cycle before its completion.
- R5: A source tag that equals `bc_tag` while `bc_valid` is high counts as available in that same cycle. This applies to operations already waiting and to the operation being inserted in that cycle. A waiting operation can therefore be issued in the cycle of the announcement.
- R6: In out-of-order mode each unit issues at most one operation per cycle. It chooses the oldest waiting operation of its class whose two sources are both available.
- R7: An operation is issued only if no operation already in a unit will use the announcement bus in cycle t+L-1. Otherwise it stays waiting, and no more than one tag is announced per cycle.
- R8: At most one completion is reported per cycle. Completions follow the order of their announcements.
- R9: When `cfg_inorder` is 1, only the oldest operation in the pool may be issued. It is issued only when it is ready and its bus slot is free, so at most one operation is issued per cycle.
- R10: `ins_ready` is 0 exactly when every slot is occupied.
- R11: Age ordering stays correct after the internal sequence counter wraps around.
- R12: For the five-operation chain add, mul, add, div, add, where the multiply and the divide need the first add, and the last add needs the divide and the second add, completions respect the dependences. The last completion is in cycle 13 in out-of-order mode and in cycle 14 in in-order mode, counting the first insertion cycle as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_inorder | input | 1 | 1 = issue only the oldest operation |
| ins_valid | input | 1 | Insert request |
| ins_op | input | 2 | Operation class (0 add, 1 mul, 2 div, 3 add) |
| ins_dst | input | TAG_W | Destination tag |
| ins_src1 | input | TAG_W | First source tag |
| ins_rdy1 | input | 1 | First source already available |
| ins_src2 | input | TAG_W | Second source tag |
| ins_rdy2 | input | 1 | Second source already available |
| ins_ready | output | 1 | A free slot exists |
| iss_valid | output | 3 | Per-unit issue strobe (add, mul, div) |
| bc_valid | output | 1 | Tag announcement valid |
| bc_tag | output | TAG_W | Announced tag |
| cmp_valid | output | 1 | Completion toward the reorder buffer |
| cmp_tag | output | TAG_W | Completed destination tag |

## Verification
A lost wakeup bit or a stale slot shows up on `iss_valid` in the very cycle the reference model expects an issue, so it is caught within one clock. Corrupted age state changes which operation a unit picks. That difference shows up first as a different `iss_valid` pattern, and later, at the latest L cycles after the wrong issue, as a different tag on `bc_tag` or `cmp_tag`. A wrong bus reservation gives a second announcement in an occupied cycle or a missing issue, both visible on the next edge. Free-slot bookkeeping errors show up on `ins_ready`.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int NUM_UNITS = 3;

    typedef enum logic [1:0] {
        OPC_ADD = 2'd0,
        OPC_MUL = 2'd1,
        OPC_DIV = 2'd2,
        OPC_ALT = 2'd3
    } opc_e;

    // Execution unit index for an operation class; the spare code goes to the adder.
    function automatic logic [1:0] unit_of(input logic [1:0] opc);
        case (opc)
            OPC_MUL: return 2'd1;
            OPC_DIV: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/rs_age_select.sv
module rs_age_select #(
    parameter int N     = 8,
    parameter int SEQ_W = 5,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]            req,
    input  logic [N-1:0][SEQ_W-1:0] seq,
    output logic                    gnt_v,
    output logic [IDX_W-1:0]        gnt_idx
);
    // a is older than b when the wrapped difference is negative
    function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
        logic [SEQ_W-1:0] diff;
        diff = a - b;
        return diff[SEQ_W-1];
    endfunction

    always_comb begin
        gnt_v   = 1'b0;
        gnt_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!gnt_v || older(seq[i], seq[gnt_idx]))) begin
                gnt_v   = 1'b1;
                gnt_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_exec_pipe.sv
module rs_exec_pipe #(
    parameter int LAT   = 3,
    parameter int TAG_W = 4,
    parameter int OUT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_v,
    input  logic [TAG_W-1:0] issue_tag,
    output logic [OUT_W-1:0] stage_v,
    output logic             bc_v,
    output logic [TAG_W-1:0] bc_tag,
    output logic             done_v,
    output logic [TAG_W-1:0] done_tag
);
    typedef struct packed {
        logic [LAT-1:0]            v;
        logic [LAT-1:0][TAG_W-1:0] tag;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.v   = {pipe_q.v[LAT-2:0], issue_v};
        pipe_d.tag = {pipe_q.tag[LAT-2:0], issue_tag};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    // stage k holds an operation issued k+1 cycles ago
    for (genvar k = 0; k < OUT_W; k++) begin : g_stage
        if (k < LAT) begin : g_live
            assign stage_v[k] = pipe_q.v[k];
        end else begin : g_pad
            assign stage_v[k] = 1'b0;
        end
    end

    assign bc_v     = pipe_q.v[LAT-2];
    assign bc_tag   = pipe_q.tag[LAT-2];
    assign done_v   = pipe_q.v[LAT-1];
    assign done_tag = pipe_q.tag[LAT-1];
endmodule

// File: rtl/rs_scheduler.sv
module rs_scheduler
    import rs_pkg::*;
#(
    parameter int N_ENT   = 8,
    parameter int TAG_W   = 4,
    parameter int LAT_ADD = 3,
    parameter int LAT_MUL = 5,
    parameter int LAT_DIV = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_inorder,
    input  logic                 ins_valid,
    input  logic [1:0]           ins_op,
    input  logic [TAG_W-1:0]     ins_dst,
    input  logic [TAG_W-1:0]     ins_src1,
    input  logic                 ins_rdy1,
    input  logic [TAG_W-1:0]     ins_src2,
    input  logic                 ins_rdy2,
    output logic                 ins_ready,
    output logic [NUM_UNITS-1:0] iss_valid,
    output logic                 bc_valid,
    output logic [TAG_W-1:0]     bc_tag,
    output logic                 cmp_valid,
    output logic [TAG_W-1:0]     cmp_tag
);
    localparam int IDX_W   = $clog2(N_ENT);
    localparam int SEQ_W   = IDX_W + 2;
    localparam int LAT_MX1 = (LAT_ADD > LAT_MUL) ? LAT_ADD : LAT_MUL;
    localparam int LAT_MAX = (LAT_MX1 > LAT_DIV) ? LAT_MX1 : LAT_DIV;
    localparam int LAT_TAB [NUM_UNITS] = '{LAT_ADD, LAT_MUL, LAT_DIV};

    typedef struct packed {
        logic             valid;
        logic [1:0]       unit;
        logic [TAG_W-1:0] dst;
        logic [TAG_W-1:0] src1;
        logic             rdy1;
        logic [TAG_W-1:0] src2;
        logic             rdy2;
        logic [SEQ_W-1:0] seq;
    } slot_t;

    typedef struct packed {
        slot_t [N_ENT-1:0] slot;
        logic [SEQ_W-1:0]  seq_ctr;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_UNITS-1:0]              bc_vec, done_vec, slot_busy, gnt_v;
    logic [NUM_UNITS-1:0][TAG_W-1:0]   bc_tags, done_tags, iss_tag;
    logic [NUM_UNITS-1:0][LAT_MAX-1:0] stage_all;
    logic [NUM_UNITS-1:0][IDX_W-1:0]   gnt_idx;
    logic [NUM_UNITS-1:0][N_ENT-1:0]   req;
    logic [N_ENT-1:0]                  woke1, woke2, occupied;
    logic [N_ENT-1:0][SEQ_W-1:0]       seq_vec;
    logic                              old_v;
    logic [IDX_W-1:0]                  old_idx;

    // ---------------- execution units and per-unit pickers ----------------
    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        rs_age_select #(.N(N_ENT), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_pick (
            .req     (req[g]),
            .seq     (seq_vec),
            .gnt_v   (gnt_v[g]),
            .gnt_idx (gnt_idx[g])
        );

        assign iss_valid[g] = gnt_v[g] && !slot_busy[g];
        assign iss_tag[g]   = st_q.slot[gnt_idx[g]].dst;

        rs_exec_pipe #(.LAT(LAT_TAB[g]), .TAG_W(TAG_W), .OUT_W(LAT_MAX)) u_pipe (
            .clk       (clk),
            .rst_n     (rst_n),
            .issue_v   (iss_valid[g]),
            .issue_tag (iss_tag[g]),
            .stage_v   (stage_all[g]),
            .bc_v      (bc_vec[g]),
            .bc_tag    (bc_tags[g]),
            .done_v    (done_vec[g]),
            .done_tag  (done_tags[g])
        );
    end

    // oldest occupied slot, used by the in-order mode
    rs_age_select #(.N(N_ENT), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_oldest (
        .req     (occupied),
        .seq     (seq_vec),
        .gnt_v   (old_v),
        .gnt_idx (old_idx)
    );

    // ---------------- shared bus and completion merge ----------------
    always_comb begin
        bc_valid  = |bc_vec;
        cmp_valid = |done_vec;
        bc_tag    = '0;
        cmp_tag   = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            if (bc_vec[u])   bc_tag  = bc_tag  | bc_tags[u];
            if (done_vec[u]) cmp_tag = cmp_tag | done_tags[u];
        end
    end

    // A unit with latency L announces L-1 cycles after issue; a longer unit
    // holding an operation in stage Lv-L-1 would announce in that same cycle.
    always_comb begin
        slot_busy = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            for (int v = 0; v < NUM_UNITS; v++) begin
                for (int k = 0; k < LAT_MAX; k++) begin
                    if ((k == LAT_TAB[v] - LAT_TAB[u] - 1) && stage_all[v][k]) begin
                        slot_busy[u] = 1'b1;
                    end
                end
            end
        end
    end

    // ---------------- wakeup and request vectors ----------------
    always_comb begin
        req = '0;
        for (int i = 0; i < N_ENT; i++) begin
            occupied[i] = st_q.slot[i].valid;
            seq_vec[i]  = st_q.slot[i].seq;
            woke1[i]    = st_q.slot[i].rdy1 || (bc_valid && st_q.slot[i].src1 == bc_tag);
            woke2[i]    = st_q.slot[i].rdy2 || (bc_valid && st_q.slot[i].src2 == bc_tag);
            for (int u = 0; u < NUM_UNITS; u++) begin
                req[u][i] = st_q.slot[i].valid && woke1[i] && woke2[i]
                         && (st_q.slot[i].unit == 2'(u))
                         && (!cfg_inorder || (old_v && old_idx == IDX_W'(i)));
            end
        end
    end

    assign ins_ready = !(&occupied);

    // ---------------- next state ----------------
    always_comb begin
        logic [IDX_W-1:0] free_idx;
        st_d     = st_q;
        free_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!st_q.slot[i].valid) free_idx = IDX_W'(i);
        end
        for (int i = 0; i < N_ENT; i++) begin
            st_d.slot[i].rdy1 = woke1[i];
            st_d.slot[i].rdy2 = woke2[i];
            for (int u = 0; u < NUM_UNITS; u++) begin
                if (iss_valid[u] && gnt_idx[u] == IDX_W'(i)) st_d.slot[i].valid = 1'b0;
            end
        end
        if (ins_valid && ins_ready) begin
            st_d.slot[free_idx].valid = 1'b1;
            st_d.slot[free_idx].unit  = unit_of(ins_op);
            st_d.slot[free_idx].dst   = ins_dst;
            st_d.slot[free_idx].src1  = ins_src1;
            st_d.slot[free_idx].rdy1  = ins_rdy1 || (bc_valid && ins_src1 == bc_tag);
            st_d.slot[free_idx].src2  = ins_src2;
            st_d.slot[free_idx].rdy2  = ins_rdy2 || (bc_valid && ins_src2 == bc_tag);
            st_d.slot[free_idx].seq   = st_q.seq_ctr;
            st_d.seq_ctr              = st_q.seq_ctr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rs_scheduler_chk.sv
module rs_scheduler_chk #(
    parameter int NU    = 3,
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_inorder,
    input logic [NU-1:0]    iss_valid,
    input logic [NU-1:0]    bc_vec,
    input logic [NU-1:0]    done_vec,
    input logic             bc_valid,
    input logic [TAG_W-1:0] bc_tag,
    input logic             cmp_valid,
    input logic [TAG_W-1:0] cmp_tag
);
    // R7: the bus reservation keeps the units from announcing together
    a_r7_single_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bc_vec));

    // R8: completions from separate units never coincide
    a_r8_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_vec));

    // R4: each announcement is followed by the completion of the same tag
    a_r4_bcast_leads: assert property (@(posedge clk) disable iff (!rst_n)
        bc_valid |=> (cmp_valid && cmp_tag == $past(bc_tag)));

    // R4: no completion without an announcement in the previous cycle
    a_r4_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |-> $past(bc_valid));

    // R9: in-order mode never issues on two units at once
    a_r9_inorder_one: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_inorder |-> ($countones(iss_valid) <= 1));
endmodule

bind rs_scheduler rs_scheduler_chk #(.NU(rs_pkg::NUM_UNITS), .TAG_W(TAG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_inorder (cfg_inorder),
    .iss_valid   (iss_valid),
    .bc_vec      (bc_vec),
    .done_vec    (done_vec),
    .bc_valid    (bc_valid),
    .bc_tag      (bc_tag),
    .cmp_valid   (cmp_valid),
    .cmp_tag     (cmp_tag)
);

// File: tb/rs_scheduler_tb.sv
module rs_scheduler_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int LATS [3]   = '{3, 5, 7};

    logic       clk = 1'b0, rst_n = 1'b0, cfg_inorder = 1'b0, ins_valid = 1'b0;
    logic [1:0] ins_op = '0;
    logic [3:0] ins_dst = '0, ins_src1 = '0, ins_src2 = '0;
    logic       ins_rdy1 = 1'b0, ins_rdy2 = 1'b0;
    logic       ins_ready, bc_valid, cmp_valid;
    logic [3:0] bc_tag, cmp_tag;
    logic [2:0] iss_valid;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rs_scheduler u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_inorder(cfg_inorder),
        .ins_valid(ins_valid), .ins_op(ins_op), .ins_dst(ins_dst),
        .ins_src1(ins_src1), .ins_rdy1(ins_rdy1), .ins_src2(ins_src2), .ins_rdy2(ins_rdy2),
        .ins_ready(ins_ready), .iss_valid(iss_valid), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag)
    );

    typedef struct {int unit; int dst; int s1; int s2; bit r1; bit r2;} m_ent_t;
    typedef struct {int tag; int bcc; int donec;} m_fl_t;

    m_ent_t mq[$];
    m_fl_t  mf[$];
    int     cyc;
    int     n_checks = 0, n_err = 0;
    int     done_at [16];
    bit     finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at model cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    function automatic bit slot_free(input int u);
        foreach (mf[k]) if (mf[k].bcc == cyc + LATS[u] - 1) return 1'b0;
        return 1'b1;
    endfunction

    // one cycle: drive inputs, compare outputs with the model, advance the model
    task automatic step(input bit v, input int op, input int dst,
                        input int s1, input bit r1, input int s2, input bit r2);
        int ebc, ecm, nsz;
        int pick [3];
        bit rd1 [N], rd2 [N];
        bit [2:0] eiss;
        ins_valid = v; ins_op = 2'(op); ins_dst = 4'(dst);
        ins_src1 = 4'(s1); ins_rdy1 = r1; ins_src2 = 4'(s2); ins_rdy2 = r2;
        #1;
        ebc = -1; ecm = -1;
        foreach (mf[k]) begin
            if (mf[k].bcc == cyc)   ebc = mf[k].tag;
            if (mf[k].donec == cyc) ecm = mf[k].tag;
        end
        nsz = mq.size();
        for (int k = 0; k < nsz; k++) begin
            rd1[k] = mq[k].r1 || (ebc >= 0 && mq[k].s1 == ebc);
            rd2[k] = mq[k].r2 || (ebc >= 0 && mq[k].s2 == ebc);
        end
        for (int u = 0; u < 3; u++) pick[u] = -1;
        if (cfg_inorder) begin
            // R9: only the head of the age queue may go
            if (nsz > 0 && rd1[0] && rd2[0] && slot_free(mq[0].unit)) pick[mq[0].unit] = 0;
        end else begin
            for (int u = 0; u < 3; u++) begin
                for (int k = 0; k < nsz; k++) begin
                    if (pick[u] < 0 && mq[k].unit == u && rd1[k] && rd2[k]) pick[u] = k;
                end
                if (pick[u] >= 0 && !slot_free(u)) pick[u] = -1;  // R7 stall
            end
        end
        for (int u = 0; u < 3; u++) eiss[u] = (pick[u] >= 0);

        chk(ins_ready == (nsz < N), "R10 ins_ready", int'(ins_ready), int'(nsz < N));
        chk(bc_valid == (ebc >= 0), "R4 R5 bc_valid", int'(bc_valid), int'(ebc >= 0));
        if (ebc >= 0) chk(int'(bc_tag) == ebc, "R4 bc_tag", int'(bc_tag), ebc);
        chk(cmp_valid == (ecm >= 0), "R3 R8 cmp_valid", int'(cmp_valid), int'(ecm >= 0));
        if (ecm >= 0) chk(int'(cmp_tag) == ecm, "R3 R8 cmp_tag", int'(cmp_tag), ecm);
        chk(iss_valid == eiss, "R2 R6 R7 R9 R11 iss_valid", int'(iss_valid), int'(eiss));
        if (cmp_valid) done_at[cmp_tag] = cyc;

        for (int u = 0; u < 3; u++)
            if (pick[u] >= 0) mf.push_back('{mq[pick[u]].dst, cyc + LATS[u] - 1, cyc + LATS[u]});
        for (int k = 0; k < nsz; k++) begin
            mq[k].r1 = rd1[k];
            mq[k].r2 = rd2[k];
        end
        for (int k = nsz - 1; k >= 0; k--)
            if (pick[0] == k || pick[1] == k || pick[2] == k) mq.delete(k);
        if (v && nsz < N)
            mq.push_back('{(op == 1) ? 1 : (op == 2) ? 2 : 0, dst, s1, s2,
                           r1 || (ebc >= 0 && s1 == ebc), r2 || (ebc >= 0 && s2 == ebc)});
        for (int k = mf.size() - 1; k >= 0; k--) if (mf[k].donec <= cyc) mf.delete(k);
        cyc++;
        @(negedge clk);
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 0, 1'b1, 0, 1'b1);
    endtask

    task automatic do_reset(input bit inorder);
        rst_n = 1'b0; ins_valid = 1'b0; cfg_inorder = inorder;
        mq.delete(); mf.delete(); cyc = 0;
        for (int t = 0; t < 16; t++) done_at[t] = -1;
        repeat (2) @(negedge clk);
        chk(bc_valid == 1'b0, "R1 bc_valid in reset", int'(bc_valid), 0);
        chk(cmp_valid == 1'b0, "R1 cmp_valid in reset", int'(cmp_valid), 0);
        chk(iss_valid == 3'b0, "R1 iss_valid in reset", int'(iss_valid), 0);
        chk(ins_ready == 1'b1, "R1 ins_ready in reset", int'(ins_ready), 1);
        rst_n = 1'b1;
    endtask

    // R12: dependent chain; tags are the register numbers
    task automatic run_chain(input bit inorder, output int last);
        do_reset(inorder);
        step(1'b1, 0, 3, 1, 1'b1, 2, 1'b1);
        step(1'b1, 1, 4, 1, 1'b1, 3, 1'b0);
        step(1'b1, 0, 5, 8, 1'b1, 9, 1'b1);
        step(1'b1, 2, 6, 1, 1'b1, 3, 1'b0);
        step(1'b1, 0, 7, 6, 1'b0, 5, 1'b0);
        repeat (14) idle();
        last = done_at[7];
        chk(done_at[4] > done_at[3], "R12 mul after add", done_at[4], done_at[3] + 1);
        chk(done_at[6] > done_at[3], "R12 div after add", done_at[6], done_at[3] + 1);
        chk(done_at[7] > done_at[6] && done_at[7] > done_at[5], "R12 last add after producers",
            done_at[7], done_at[6] + 1);
        chk(last == (inorder ? 14 : 13), "R12 chain length", last, inorder ? 14 : 13);
        if (!inorder) chk(done_at[6] == 11, "R5 wake at insert", done_at[6], 11);
    endtask

    initial begin
        int t_ooo, t_ino;
        void'($urandom(11));
        run_chain(1'b0, t_ooo);
        run_chain(1'b1, t_ino);
        chk(t_ooo < t_ino, "R12 out-of-order faster", t_ooo, t_ino - 1);

        // R7: an add whose announcement would collide with a multiply waits one cycle
        do_reset(1'b0);
        step(1'b1, 1, 1, 0, 1'b1, 0, 1'b1);
        idle();
        step(1'b1, 3, 2, 0, 1'b1, 0, 1'b1);
        repeat (8) idle();
        chk(done_at[1] == 6, "R3 mul latency", done_at[1], 6);
        chk(done_at[2] == 7, "R7 add stalled by bus", done_at[2], 7);

        // R10: fill every slot with operations waiting on a tag never produced
        do_reset(1'b0);
        for (int k = 0; k < N; k++) step(1'b1, k % 3, k + 1, 13, 1'b0, 0, 1'b1);
        chk(ins_ready == 1'b0, "R10 full", int'(ins_ready), 0);
        repeat (3) idle();

        // R11: random traffic, long enough for the sequence counter to wrap
        for (int blk = 0; blk < 24; blk++) begin
            do_reset(blk[0]);
            for (int c = 0; c < 60; c++) begin
                bit go;
                go = ($urandom % 4 != 0) && (mq.size() < N);
                step(go, int'($urandom % 4), int'($urandom % 15) + 1,
                     int'($urandom % 16), bit'($urandom % 2), int'($urandom % 16), bit'($urandom % 3 != 0));
            end
            repeat (10) idle();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule